// File: doc/BRIEF.md
# Bridge Fault and Shutdown Controller

This block is the central protection logic of a three-phase gate driver. It receives three already-digitized conditions: a trip bit from the over-current/over-temperature comparator, an enable request, and a flag that reports undervoltage on the low-side supply. From these it builds one kill signal that forces all six gate outputs off, plus an active-low fault flag for the host controller. The per-phase gating and the input filtering of the phase commands sit in other blocks.

The three conditions are handled differently. A trip must persist through a blanking window before it counts. It then kills the outputs and raises the fault flag, each after its own fixed propagation delay. After the trip goes away, both stay asserted until a programmable clear timer, counted in clock cycles, has run out. The timer replaces an external RC network. Undervoltage kills the outputs and flags a fault only while it lasts. The enable request passes through a persistence filter. It only kills the outputs and never touches the fault flag. After reset the block starts faulted, with the outputs killed, until it sees a good supply and a filtered enable.

All time constants are parameters in clock cycles. `EN_FILT_CYC` is the enable filter length, `TRIP_BLANK_CYC` the trip blanking length, and `KILL_DLY_CYC` and `FLAG_DLY_CYC` are the extra propagation stages on the trip path. The clear time comes from the `clr_time_i` input and should be held stable while a trip is being cleared.

Top module: `bridge_guard`

## Requirements
- R1: While `rst` is high, `kill_o`=1 and `fault_n_o`=0. After `rst` falls with `uv_i`=0 and `en_i`=1, `fault_n_o` rises at the 2nd clock edge and `kill_o` falls at edge EN_FILT_CYC+1.
- R2: When `trip_i`=1 is sampled on at least TRIP_BLANK_CYC consecutive edges, `kill_o` rises at edge TRIP_BLANK_CYC+KILL_DLY_CYC+2, counted from the first edge that sees the trip.
- R3: Under the same trip, `fault_n_o` falls at edge TRIP_BLANK_CYC+FLAG_DLY_CYC+2.
- R4: A trip pulse seen on fewer than TRIP_BLANK_CYC consecutive edges changes neither `kill_o` nor `fault_n_o`.
- R5: Once a qualified trip drops, let T = max(`clr_time_i`,1). `kill_o` falls at edge T+KILL_DLY_CYC+2 and `fault_n_o` rises at edge T+FLAG_DLY_CYC+2 after the drop. A clear time of 0 behaves like 1.
- R6: A qualified trip that returns before the clear timer has expired restarts the timer. The release then follows R5, counted from the last drop, and `kill_o` stays 1 in between.
- R7: `uv_i`=1 (undervoltage) sets `kill_o`=1 and `fault_n_o`=0 at the 2nd edge. Both release at the 2nd edge after `uv_i` returns to 0, with no clear timer.
- R8: `en_i`=0 held for at least EN_FILT_CYC edges sets `kill_o`=1 at edge EN_FILT_CYC+1. `en_i`=1 held just as long clears it at edge EN_FILT_CYC+1.
- R9: A change of `en_i` held for fewer than EN_FILT_CYC edges does not change `kill_o`.
- R10: The enable input never changes `fault_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_i | input | 1 | Over-current/over-temperature trip, 1 = active |
| en_i | input | 1 | Enable request, 1 = outputs may run |
| uv_i | input | 1 | Low-side supply undervoltage, 1 = supply low |
| clr_time_i | input | CLR_W | Fault clear time in clock cycles |
| kill_o | output | 1 | 1 = force all six gate outputs off |
| fault_n_o | output | 1 | Fault flag, 0 = fault reported |

## Verification
Trip pulses are swept in length on both sides of the blanking window. This separates pulses that are ignored from pulses that latch a fault, and the latencies of the kill and flag paths show that both delays are in place. The clear time is swept over 0, 1, 2, 5 and 20 cycles. The release edges must move one-for-one with it, which tells the timer apart from a fixed hold. A second trip inside the hold window shows the timer restarting. Enable pulses swept across the filter length, and an undervoltage episode under a long clear time, show that enable never moves the fault flag and that undervoltage releases without the timer.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;
  // Collected shutdown causes, one bit per source
  typedef struct packed {
    logic uv;         // supply low
    logic dis;        // filtered enable is off
    logic trip_kill;  // trip path, kill branch after delay
    logic trip_flag;  // trip path, flag branch after delay
  } shut_src_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val);
  endfunction
endpackage

// File: rtl/bridge_guard_filter.sv
module bridge_guard_filter #(
  parameter int unsigned FILT_CYC = 4,
  parameter logic        RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CNTW = bridge_guard_pkg::cnt_width(FILT_CYC);
  localparam logic [CNTW-1:0] LAST = CNTW'(FILT_CYC - 1);

  logic [CNTW-1:0] cnt;
  logic            q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RST_VAL;
      cnt <= '0;
    end else if (din == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign dout = q;

  // R9: the filtered level moves only to a value the input held
  p_filt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> (q == $past(din)));
  // R8: persistence counter never passes its limit
  p_filt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < FILT_CYC);
endmodule

// File: rtl/bridge_guard_blank.sv
module bridge_guard_blank #(
  parameter int unsigned BLANK_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic qual
);
  localparam int unsigned CNTW = bridge_guard_pkg::cnt_width(BLANK_CYC);
  localparam logic [CNTW-1:0] LAST = CNTW'(BLANK_CYC - 1);

  logic [CNTW-1:0] cnt;
  logic            q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!raw) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qual = q;

  // R4: a dropped trip is never qualified on the next cycle
  p_blank_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !raw |=> !qual);
  // R4: qualification only arises from a present trip
  p_blank_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> $past(raw));
endmodule

// File: rtl/bridge_guard_clr_timer.sv
module bridge_guard_clr_timer #(
  parameter int unsigned CLR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip,
  input  logic [CLR_W-1:0] clr_time,
  output logic             active
);
  logic [CLR_W-1:0] cnt;
  logic             act;
  logic [CLR_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (trip) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act) begin
      if (next_cnt >= {1'b0, clr_time}) begin
        act <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= next_cnt[CLR_W-1:0];
      end
    end
  end

  assign active = act;

  // R2: a qualified trip always holds the fault state next cycle
  p_tmr_set_r2: assert property (@(posedge clk) disable iff (rst)
    trip |=> active);
  // R6: a trip restarts the count from zero
  p_tmr_restart_r6: assert property (@(posedge clk) disable iff (rst)
    trip |=> (cnt == '0));
  // R5: the fault state only ends when no trip was present
  p_tmr_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(act) |-> !$past(trip));
endmodule

// File: rtl/bridge_guard_delay.sv
module bridge_guard_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DLY == 0) begin : g_thru
      assign dout = din;
    end else begin : g_pipe
      logic [DLY-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= din;
          for (int i = 1; i < DLY; i++) sr[i] <= sr[i-1];
        end
      end
      assign dout = sr[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int unsigned EN_FILT_CYC    = 44,
  parameter int unsigned TRIP_BLANK_CYC = 50,
  parameter int unsigned KILL_DLY_CYC   = 42,
  parameter int unsigned FLAG_DLY_CYC   = 23,
  parameter int unsigned CLR_W          = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip_i,
  input  logic             en_i,
  input  logic             uv_i,
  input  logic [CLR_W-1:0] clr_time_i,
  output logic             kill_o,
  output logic             fault_n_o
);
  import bridge_guard_pkg::*;

  logic      uv_q;
  logic      en_ok;
  logic      trip_q;
  logic      trip_act;
  logic      kill_trip;
  logic      flag_trip;
  shut_src_t src;

  // Supply flag register; assume a low supply until shown otherwise
  always_ff @(posedge clk) begin
    if (rst) uv_q <= 1'b1;
    else     uv_q <= uv_i;
  end

  bridge_guard_filter #(.FILT_CYC(EN_FILT_CYC), .RST_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst(rst), .din(en_i), .dout(en_ok));

  bridge_guard_blank #(.BLANK_CYC(TRIP_BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .raw(trip_i), .qual(trip_q));

  bridge_guard_clr_timer #(.CLR_W(CLR_W)) u_timer (
    .clk(clk), .rst(rst), .trip(trip_q), .clr_time(clr_time_i),
    .active(trip_act));

  bridge_guard_delay #(.DLY(KILL_DLY_CYC)) u_kill_dly (
    .clk(clk), .rst(rst), .din(trip_act), .dout(kill_trip));

  bridge_guard_delay #(.DLY(FLAG_DLY_CYC)) u_flag_dly (
    .clk(clk), .rst(rst), .din(trip_act), .dout(flag_trip));

  always_comb begin
    src.uv        = uv_q;
    src.dis       = ~en_ok;
    src.trip_kill = kill_trip;
    src.trip_flag = flag_trip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_o    <= 1'b1;
      fault_n_o <= 1'b0;
    end else begin
      kill_o    <= src.uv | src.dis | src.trip_kill;
      fault_n_o <= ~(src.uv | src.trip_flag);
    end
  end

  // R7: undervoltage reaches both outputs one cycle later
  p_uv_out_r7: assert property (@(posedge clk) disable iff (rst)
    uv_q |=> (kill_o && !fault_n_o));
  // R10: with no supply or trip cause, the flag is clear whatever enable does
  p_en_noflag_r10: assert property (@(posedge clk) disable iff (rst)
    (!uv_q && !flag_trip) |=> fault_n_o);
  // R2: the delayed trip kill always reaches the output
  p_trip_kill_r2: assert property (@(posedge clk) disable iff (rst)
    kill_trip |=> kill_o);
endmodule

// File: tb/bridge_guard_test.sv
`timescale 1ns/1ps
module bridge_guard_test;
  localparam int EF = 4;
  localparam int BL = 3;
  localparam int KD = 5;
  localparam int FD = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_i = 1'b0;
  logic en_i = 1'b1;
  logic uv_i = 1'b0;
  logic [CW-1:0] clr_time_i = 8'd20;
  logic kill_o, fault_n_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_guard #(.EN_FILT_CYC(EF), .TRIP_BLANK_CYC(BL), .KILL_DLY_CYC(KD),
                 .FLAG_DLY_CYC(FD), .CLR_W(CW)) uut (
    .clk(clk), .rst(rst), .trip_i(trip_i), .en_i(en_i), .uv_i(uv_i),
    .clr_time_i(clr_time_i), .kill_o(kill_o), .fault_n_o(fault_n_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts at a falling edge; returns the index of the first rising edge
  // after which each output differs from its starting value (0 = never)
  task automatic watch(input int maxn, output int tk, output int tf);
    logic k0, f0;
    k0 = kill_o; f0 = fault_n_o; tk = 0; tf = 0;
    for (int n = 1; n <= maxn; n++) begin
      @(posedge clk); #1;
      if (tk == 0 && kill_o != k0) tk = n;
      if (tf == 0 && fault_n_o != f0) tf = n;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trip_pulse(input int len, output int tk, output int tf);
    fork
      begin trip_i = 1'b1; repeat (len) @(negedge clk); trip_i = 1'b0; end
      watch(40, tk, tf);
    join
  endtask

  task automatic en_pulse(input int len, output int tk, output int tf);
    fork
      begin en_i = 1'b0; repeat (len) @(negedge clk); en_i = 1'b1; end
      watch(20, tk, tf);
    join
  endtask

  initial begin
    int tk, tf, tmax;
    // R1: reset state
    idle(5); #1;
    chk("R1", "kill_o in reset", kill_o, 1);
    chk("R1", "fault_n_o in reset", fault_n_o, 0);
    @(negedge clk);
    rst = 1'b0;
    watch(12, tk, tf);
    chk("R1", "fault release edge", tf, 2);
    chk("R1", "kill release edge", tk, EF + 1);
    idle(4);

    // R4 / R2 / R3: trip pulse length sweep across the blanking window
    for (int len = 1; len <= BL + 2; len++) begin
      @(negedge clk);
      trip_pulse(len, tk, tf);
      if (len < BL) begin
        chk("R4", $sformatf("short trip %0d kill", len), tk, 0);
        chk("R4", $sformatf("short trip %0d flag", len), tf, 0);
      end else begin
        chk("R2", $sformatf("trip %0d kill edge", len), tk, BL + KD + 2);
        chk("R3", $sformatf("trip %0d flag edge", len), tf, BL + FD + 2);
      end
      idle(40);
      chk("R5", "idle kill after clear", kill_o, 0);
      chk("R5", "idle flag after clear", fault_n_o, 1);
    end

    // R5: clear time sweep
    foreach (tmax_list[i]) begin
      clr_time_i = 8'(tmax_list[i]);
      tmax = (tmax_list[i] < 1) ? 1 : tmax_list[i];
      @(negedge clk);
      trip_i = 1'b1;
      idle(15);
      chk("R5", "kill held before drop", kill_o, 1);
      trip_i = 1'b0;
      watch(40, tk, tf);
      chk("R5", $sformatf("T=%0d kill release", tmax_list[i]), tk, tmax + KD + 2);
      chk("R5", $sformatf("T=%0d flag release", tmax_list[i]), tf, tmax + FD + 2);
      idle(10);
    end

    // R6: re-trip inside the clear window restarts the timer
    clr_time_i = 8'd20;
    @(negedge clk);
    trip_i = 1'b1; idle(15);
    trip_i = 1'b0; idle(10);
    chk("R6", "kill held in gap", kill_o, 1);
    chk("R6", "flag held in gap", fault_n_o, 0);
    trip_i = 1'b1; idle(6);
    chk("R6", "kill held on re-trip", kill_o, 1);
    trip_i = 1'b0;
    watch(40, tk, tf);
    chk("R6", "kill release after restart", tk, 20 + KD + 2);
    chk("R6", "flag release after restart", tf, 20 + FD + 2);
    idle(10);

    // R7: undervoltage, no clear timer even with a long clear time
    uv_i = 1'b1;
    watch(10, tk, tf);
    chk("R7", "uv kill edge", tk, 2);
    chk("R7", "uv flag edge", tf, 2);
    idle(3);
    uv_i = 1'b0;
    watch(30, tk, tf);
    chk("R7", "uv kill release", tk, 2);
    chk("R7", "uv flag release", tf, 2);
    idle(5);

    // R8 / R10: held enable off and back on
    en_i = 1'b0;
    watch(20, tk, tf);
    chk("R8", "disable kill edge", tk, EF + 1);
    chk("R10", "disable leaves flag", tf, 0);
    en_i = 1'b1;
    watch(20, tk, tf);
    chk("R8", "enable release edge", tk, EF + 1);
    chk("R10", "enable leaves flag", tf, 0);
    idle(3);

    // R9 / R10: short enable-off pulses
    for (int len = 1; len < EF; len++) begin
      @(negedge clk);
      en_pulse(len, tk, tf);
      chk("R9", $sformatf("enable glitch %0d kill", len), tk, 0);
      chk("R10", $sformatf("enable glitch %0d flag", len), tf, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  int tmax_list[5] = '{0, 1, 2, 5, 20};

  initial begin
    #(8 * 100000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule